// File: doc/BRIEF.md
# Color Palette Lookup with Auto-Incrementing CPU Port

This block holds the color lookup table of a palette DAC and the processor-side port that fills it. Software picks a starting entry through a write-index register. It then streams color components into a data register, one byte per access. The components go in as red, then green, then blue. Red and green wait in staging registers. When blue arrives, the whole entry is written to the table in one cycle and the write index moves to the next entry. One index write followed by a run of data writes can therefore reload any number of consecutive entries.

On the display side, every cycle the pixel index is ANDed with a mask register and used to look up an 18-bit color, made of three 6-bit components. A read-index register and a read strobe give software the same triplet-ordered sequence for reading back.

The four registers sit on a 2-bit select: 0 is the write index, 1 is the color data, 2 is the pixel mask and 3 is the read index.

Top module: `palDac`

## Requirements
- R1: After reset, every table entry is zero, the pixel mask is 0xFF, both indices are 0 and both component sequences stand at red.
- R2: A write with select 0 sets the write index to busData and restarts the write sequence at red, even in the middle of a triplet.
- R3: Writes with select 1 take red, then green, then blue from busData[5:0], and busData[7:6] are ignored. The table entry changes only when the blue write arrives, and it is written whole.
- R4: After each blue write the write index increments by one and wraps from 255 to 0.
- R5: A write with select 2 loads the pixel mask. pixColor shows the entry at (pixIdx AND mask) one clock after pixIdx is presented, with red in bits 17:12, green in 11:6 and blue in 5:0.
- R6: A write with select 3 sets the read index to busData and restarts the read sequence at red.
- R7: rdData shows the current component of the read entry, zero-extended so that bits 7:6 are 0. Each rdPop pulse advances the sequence red, then green, then blue. After blue, the read index increments and wraps from 255 to 0.
- R8: An unfinished triplet leaves the table unchanged.
- R9: One write of 0 with select 0, followed by 192 data writes, loads entries 0 to 63 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe, one cycle per access |
| busSel | input | 2 | Register select: 0 write index, 1 data, 2 mask, 3 read index |
| busData | input | 8 | Write data |
| rdPop | input | 1 | Consume the shown read component |
| rdData | output | 8 | Current read-back component, zero-extended |
| pixIdx | input | 8 | Pixel index from the display pipeline |
| pixColor | output | 18 | Looked-up color, one-cycle latency |

## Verification
The hardest cases to reach are where the index wraps: a triplet committed at entry 255 must land there and send the next triplet to entry 0. The read sequence must also cross from 255 to 0 in the middle of a stream. The bench sets both indices to 255 explicitly and streams across the boundary. A second hard case is an abandoned triplet. The bench writes red and green, rewrites the index, then reads the entry back and completes a fresh triplet, which shows that the stale staging values never reach the table.

// File: rtl/palPkg.sv
package palPkg;
  typedef enum logic [1:0] {PH_RED = 2'd0, PH_GREEN = 2'd1, PH_BLUE = 2'd2} phase_t;

  localparam logic [1:0] SEL_WIDX = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] SEL_RIDX = 2'd3;

  typedef struct packed {
    logic stageRed;
    logic stageGreen;
    logic commit;
    logic loadMask;
  } palStrobe_t;
endpackage

// File: rtl/palCtrl.sv
module palCtrl
  import palPkg::*;
#(
  parameter int IDX_W = 8,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWr,
  input  logic [1:0]       busSel,
  input  logic [BUS_W-1:0] busData,
  input  logic             rdPop,
  output palStrobe_t       strobe,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output phase_t           rdPhase
);
  phase_t wrPhase;
  logic   dataWr, ridxWr;

  assign dataWr = busWr && (busSel == SEL_DATA);
  assign ridxWr = busWr && (busSel == SEL_RIDX);

  always_comb begin
    strobe.stageRed   = dataWr && (wrPhase == PH_RED);
    strobe.stageGreen = dataWr && (wrPhase == PH_GREEN);
    strobe.commit     = dataWr && (wrPhase == PH_BLUE);
    strobe.loadMask   = busWr && (busSel == SEL_MASK);
  end

  // write-side sequence
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx   <= '0;
      wrPhase <= PH_RED;
    end else if (busWr && busSel == SEL_WIDX) begin
      wrIdx   <= busData[IDX_W-1:0];
      wrPhase <= PH_RED;
    end else if (dataWr) begin
      case (wrPhase)
        PH_RED:   wrPhase <= PH_GREEN;
        PH_GREEN: wrPhase <= PH_BLUE;
        default: begin
          wrPhase <= PH_RED;
          wrIdx   <= wrIdx + 1'b1;
        end
      endcase
    end
  end

  // read-side sequence; an index write wins over a pop in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIdx   <= '0;
      rdPhase <= PH_RED;
    end else if (ridxWr) begin
      rdIdx   <= busData[IDX_W-1:0];
      rdPhase <= PH_RED;
    end else if (rdPop) begin
      case (rdPhase)
        PH_RED:   rdPhase <= PH_GREEN;
        PH_GREEN: rdPhase <= PH_BLUE;
        default: begin
          rdPhase <= PH_RED;
          rdIdx   <= rdIdx + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/palData.sv
module palData
  import palPkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  palStrobe_t          strobe,
  input  logic [BUS_W-1:0]    busData,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [IDX_W-1:0]    rdIdx,
  input  phase_t              rdPhase,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*COMP_W-1:0] pixColor,
  output logic [BUS_W-1:0]    rdData
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int COLOR_W = 3 * COMP_W;

  logic [COLOR_W-1:0] lut [ENTRIES];
  logic [COMP_W-1:0]  stgRed, stgGreen;
  logic [IDX_W-1:0]   pixMask;
  logic [COLOR_W-1:0] rdEntry;
  logic [COMP_W-1:0]  rdComp;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgRed   <= '0;
      stgGreen <= '0;
      pixMask  <= '1;
    end else begin
      if (strobe.stageRed)   stgRed   <= busData[COMP_W-1:0];
      if (strobe.stageGreen) stgGreen <= busData[COMP_W-1:0];
      if (strobe.loadMask)   pixMask  <= busData[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) lut[i] <= '0;
    end else if (strobe.commit) begin
      lut[wrIdx] <= {stgRed, stgGreen, busData[COMP_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) pixColor <= '0;
    else       pixColor <= lut[pixIdx & pixMask];
  end

  assign rdEntry = lut[rdIdx];

  always_comb begin
    case (rdPhase)
      PH_RED:   rdComp = rdEntry[3*COMP_W-1:2*COMP_W];
      PH_GREEN: rdComp = rdEntry[2*COMP_W-1:COMP_W];
      default:  rdComp = rdEntry[COMP_W-1:0];
    endcase
    rdData = '0;
    rdData[COMP_W-1:0] = rdComp;
  end
endmodule

// File: rtl/palDac.sv
module palDac
  import palPkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWr,
  input  logic [1:0]          busSel,
  input  logic [BUS_W-1:0]    busData,
  input  logic                rdPop,
  output logic [BUS_W-1:0]    rdData,
  input  logic [IDX_W-1:0]    pixIdx,
  output logic [3*COMP_W-1:0] pixColor
);
  palStrobe_t       strobe;
  logic [IDX_W-1:0] wrIdx, rdIdx;
  phase_t           rdPhase;

  palCtrl #(.IDX_W(IDX_W), .BUS_W(BUS_W)) ctrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busData(busData),
    .rdPop(rdPop), .strobe(strobe), .wrIdx(wrIdx), .rdIdx(rdIdx), .rdPhase(rdPhase)
  );

  palData #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busData(busData), .wrIdx(wrIdx),
    .rdIdx(rdIdx), .rdPhase(rdPhase), .pixIdx(pixIdx), .pixColor(pixColor),
    .rdData(rdData)
  );
endmodule

// File: rtl/palDacChk.sv
module palDacChk
  import palPkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int COMP_W = 6,
  parameter int BUS_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWr,
  input logic [1:0]       busSel,
  input logic [BUS_W-1:0] busData,
  input logic             rdPop,
  input logic [BUS_W-1:0] rdData,
  input palStrobe_t       strobe,
  input logic [IDX_W-1:0] wrIdx,
  input logic [IDX_W-1:0] rdIdx,
  input phase_t           rdPhase
);
  a_r2_index_load: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busSel == SEL_WIDX) |=> wrIdx == $past(busData[IDX_W-1:0]));

  a_r3_commit_source: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> (busWr && busSel == SEL_DATA));

  a_r3_one_stage: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stageRed, strobe.stageGreen, strobe.commit}));

  a_r4_advance: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> wrIdx == IDX_W'($past(wrIdx) + 1'b1));

  a_r7_read_advance: assert property (@(posedge clk) disable iff (!rstN)
    (rdPop && rdPhase == PH_BLUE && !(busWr && busSel == SEL_RIDX))
      |=> rdIdx == IDX_W'($past(rdIdx) + 1'b1));

  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdData[BUS_W-1:COMP_W] == '0);
endmodule

bind palDac palDacChk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) chk (
  .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busData(busData),
  .rdPop(rdPop), .rdData(rdData), .strobe(strobe), .wrIdx(wrIdx),
  .rdIdx(rdIdx), .rdPhase(rdPhase)
);

// File: tb/palDac_test.sv
module palDac_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busSel = 2'd0;
  logic [7:0]  busData = 8'd0;
  logic        rdPop = 1'b0;
  logic [7:0]  rdData;
  logic [7:0]  pixIdx = 8'd0;
  logic [17:0] pixColor;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [17:0] model [256];

  always #2.5 clk = ~clk;

  palDac uut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel), .busData(busData),
    .rdPop(rdPop), .rdData(rdData), .pixIdx(pixIdx), .pixColor(pixColor)
  );

  function automatic logic [17:0] colorOf(int i);
    logic [5:0] r, g, b;
    r = 6'(i);
    g = 6'(i * 3 + 1);
    b = 6'(i ^ 8'h2A);
    return {r, g, b};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    busWr = 1'b1; busSel = sel; busData = d;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  // drive a triplet; upper data bits set to show they are ignored
  task automatic writeTriplet(logic [17:0] c);
    busWrite(2'd1, {2'b11, c[17:12]});
    busWrite(2'd1, {2'b10, c[11:6]});
    busWrite(2'd1, {2'b01, c[5:0]});
  endtask

  // sample the shown component, then pop it
  task automatic readComp(output logic [7:0] v);
    @(negedge clk);
    v = rdData;
    rdPop = 1'b1;
    @(negedge clk);
    rdPop = 1'b0;
  endtask

  task automatic readEntry(string req, int idx);
    logic [7:0] r, g, b;
    readComp(r); readComp(g); readComp(b);
    check(req, {r, g, b}, {2'b00, model[idx][17:12], 2'b00, model[idx][11:6], 2'b00, model[idx][5:0]});
  endtask

  task automatic lookup(string req, logic [7:0] idx, logic [17:0] exp);
    @(negedge clk);
    pixIdx = idx;
    @(negedge clk);
    check(req, pixColor, exp);
  endtask

  task automatic testReset();
    logic [7:0] v;
    lookup("R1 entry 0x9C after reset", 8'h9C, 18'd0);
    readComp(v);
    check("R1 read red after reset", v, 8'd0);
    busWrite(2'd3, 8'd0);
  endtask

  task automatic testStream();
    busWrite(2'd0, 8'd0);
    for (int i = 0; i < 64; i++) begin
      model[i] = colorOf(i);
      writeTriplet(model[i]);
    end
    lookup("R9 lookup entry 0", 8'd0, model[0]);
    lookup("R9 lookup entry 37", 8'd37, model[37]);
    lookup("R9 lookup entry 63", 8'd63, model[63]);
    lookup("R5 entry 64 untouched", 8'd64, 18'd0);
    busWrite(2'd3, 8'd0);
    for (int i = 0; i < 64; i++) readEntry("R7 R9 stream readback", i);
  endtask

  task automatic testPartial();
    logic [7:0] v;
    busWrite(2'd0, 8'd5);
    busWrite(2'd1, 8'h3F);
    busWrite(2'd1, 8'h3F);
    lookup("R8 entry 5 after two writes", 8'd5, model[5]);
    busWrite(2'd0, 8'd5);
    model[5] = 18'h15A5C;
    writeTriplet(model[5]);
    lookup("R2 restart loads red first", 8'd5, model[5]);
    busWrite(2'd3, 8'd5);
    readEntry("R3 R2 entry 5 readback", 5);
    busWrite(2'd3, 8'd3);
    readComp(v);
    busWrite(2'd3, 8'd3);
    @(negedge clk);
    check("R6 read restart shows red", rdData, {2'b00, model[3][17:12]});
  endtask

  task automatic testWrap();
    logic [7:0] v;
    busWrite(2'd0, 8'd255);
    model[255] = 18'h2B3C4;
    model[0]   = 18'h0F1E2;
    writeTriplet(model[255]);
    writeTriplet(model[0]);
    lookup("R4 entry 255", 8'd255, model[255]);
    lookup("R4 wrap to entry 0", 8'd0, model[0]);
    busWrite(2'd3, 8'd255);
    readEntry("R7 read entry 255", 255);
    readEntry("R7 read wrap entry 0", 0);
    readComp(v);
    check("R7 after wrap entry 1 red", v, {2'b00, model[1][17:12]});
  endtask

  task automatic testMask();
    busWrite(2'd2, 8'h0F);
    lookup("R5 mask 0F idx 35", 8'h35, model[5]);
    lookup("R5 mask 0F idx FF", 8'hFF, model[15]);
    busWrite(2'd2, 8'h00);
    lookup("R5 mask 00", 8'h3A, model[0]);
    busWrite(2'd2, 8'hFF);
    lookup("R5 mask FF passes all", 8'h2C, model[44]);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 18'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStream();
    testPartial();
    testWrap();
    testMask();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule